// File: doc/BRIEF.md
# Iterative Half-Adder Recursive Adder

This block adds two unsigned operands of a configurable width. It does not use a carry chain. Each bit has a half adder with a two-way input selector in front of it. While the block is idle, the selector passes the operand bits. When a start pulse is accepted, every bit forms its half-adder sum and carry at the same time. From then on, each bit cell works on its own previous sum and the carry that left the bit below it. On each clock every cell recomputes, and the carries move up one bit per cycle.

The operation ends when no internal carry is left. A zero detector over the carry register then raises `done` for one cycle, and the sum is valid at that point. The detector is gated by the selector, so it cannot fire while the operand bits are being selected. Any carry that leaves the top bit is merged into a sticky carry-out flag and takes no further part in the recursion. Latency therefore depends on the data. Operands that produce no carries finish after one step. A carry that has to ripple through every bit takes one step per bit.

The block sits behind a simple start/done exchange. The requester drives the operands and pulses `start` while the block is idle. It then waits for `done`. The result stays on the outputs until the next accepted start.

Top module: `iter_ha_adder`

## Requirements
- R1: After reset, `sum` is all zeros and `cout` and `done` are low.
- R2: When `done` is high, {`cout`,`sum`} equals `opa` + `opb` (both zero-extended by one bit) as sampled on the clock edge that accepted `start`.
- R3: `done` is high for exactly one cycle per accepted operation. It is never high in a cycle in which the block is idle and selecting the operand inputs.
- R4: If the operands produce no carry in any bit (for example all ones plus zero), `done` is high in the first cycle after the accepting edge.
- R5: If a single carry must travel through every bit (for example all ones plus one), `done` rises exactly WIDTH clock edges after the accepting edge, counting that edge. No operation takes more than WIDTH edges.
- R6: A `start` pulse that arrives while an operation is in progress is ignored, and the running result is not disturbed.
- R7: From `done` until the next accepted `start`, `sum` and `cout` hold their values whatever `opa` and `opb` do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Starts an operation when the block is idle |
| opa | input | WIDTH | First operand |
| opb | input | WIDTH | Second operand |
| sum | output | WIDTH | Result bits |
| cout | output | 1 | Carry out of the top bit |
| done | output | 1 | One-cycle completion pulse |

## Verification
Each result is due a data-dependent number of edges after the edge that accepts `start`. The minimum is one edge and the maximum is WIDTH edges, and the two directed cases above pin both ends exactly. The driver records the number of the accepting edge when it raises `start`, and it pushes the expected sum and latency before that edge. The monitor samples `done` on falling edges and computes the latency as the number of rising edges since acceptance. It compares the result in that cycle, and it also checks that `done` was low in the cycle before. Hold and ignored-start checks sample the outputs several falling edges after `done` and after a start pulse issued while busy.

// File: rtl/iter_add_pkg.sv
package iter_add_pkg;

  // half-adder evaluation: returns {carry, sum}
  function automatic logic [1:0] ha_eval(input logic x, input logic y);
    return {x & y, x ^ y};
  endfunction

  // count of edges an operation may take for a given width
  function automatic int unsigned max_steps(input int unsigned w);
    return w;
  endfunction

endpackage

// File: rtl/ha_mux_cell.sv
module ha_mux_cell
  import iter_add_pkg::*;
(
  input  logic sel,       // 0: operand bits, 1: fed-back state
  input  logic ext_a,
  input  logic ext_b,
  input  logic fb_sum,
  input  logic fb_carry,
  output logic s_nxt,
  output logic c_nxt
);
  logic x, y;
  logic [1:0] r;

  always_comb begin
    x = sel ? fb_sum   : ext_a;
    y = sel ? fb_carry : ext_b;
    r = ha_eval(x, y);
    s_nxt = r[0];
    c_nxt = r[1];
  end
endmodule

// File: rtl/carry_idle_det.sv
module carry_idle_det #(
  parameter int N = 31
) (
  input  logic [N-1:0] carries,
  input  logic         sel,
  output logic         all_clear,
  output logic         term
);
  always_comb begin
    all_clear = ~|carries;
    term      = all_clear & sel;  // gated so operand selection never completes
  end
endmodule

// File: rtl/iter_seq.sv
module iter_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic term,
  output logic busy,
  output logic load,
  output logic step
);
  logic busy_q;

  assign busy = busy_q;
  assign load = start & ~busy_q;
  assign step = busy_q & ~term;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_q <= 1'b0;
    else if (load) busy_q <= 1'b1;
    else if (term) busy_q <= 1'b0;
  end

  // R3: completion ends the operation on the next edge
  p_term_ends_r3: assert property (@(posedge clk) disable iff (!rst_n)
    term |=> !busy_q);
endmodule

// File: rtl/iter_ha_adder.sv
module iter_ha_adder
  import iter_add_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  output logic [WIDTH-1:0] sum,
  output logic             cout,
  output logic             done
);
  localparam int NC = WIDTH - 1;             // internal carries C1..C(W-1)
  localparam int CW = $clog2(WIDTH + 2);

  logic [WIDTH-1:0] sum_q;
  logic [NC-1:0]    carry_q;                 // carry_q[i-1] = carry into bit i
  logic             cout_q;
  logic [WIDTH-1:0] s_nxt, c_nxt;
  logic [WIDTH-1:0] cin_vec;
  logic             busy, load, step, term, all_clear;
  logic [CW-1:0]    iter_cnt;

  assign cin_vec = {carry_q, 1'b0};

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    ha_mux_cell u_cell (
      .sel     (busy),
      .ext_a   (opa[i]),
      .ext_b   (opb[i]),
      .fb_sum  (sum_q[i]),
      .fb_carry(cin_vec[i]),
      .s_nxt   (s_nxt[i]),
      .c_nxt   (c_nxt[i])
    );
  end

  carry_idle_det #(.N(NC)) u_det (
    .carries  (carry_q),
    .sel      (busy),
    .all_clear(all_clear),
    .term     (term)
  );

  iter_seq u_seq (
    .clk  (clk),
    .rst_n(rst_n),
    .start(start),
    .term (term),
    .busy (busy),
    .load (load),
    .step (step)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q    <= '0;
      carry_q  <= '0;
      cout_q   <= 1'b0;
      iter_cnt <= '0;
    end else if (load) begin
      sum_q    <= s_nxt;
      carry_q  <= c_nxt[NC-1:0];
      cout_q   <= c_nxt[WIDTH-1];
      iter_cnt <= CW'(1);
    end else if (step) begin
      sum_q    <= s_nxt;
      carry_q  <= c_nxt[NC-1:0];
      cout_q   <= cout_q | c_nxt[WIDTH-1];   // sticky, leaves the recursion
      iter_cnt <= iter_cnt + CW'(1);
    end
  end

  assign sum  = sum_q;
  assign cout = cout_q;
  assign done = term;

  // R3: completion is a single-cycle pulse
  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R5: the recursion never runs past WIDTH steps
  p_step_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (iter_cnt <= CW'(max_steps(WIDTH))));

  // R2: no bit ever holds sum=1 together with carry-out=1
  p_cell_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ((sum_q[NC-1:0] & carry_q) == NC'(0)));

  // R2: a captured top carry is never lost during the recursion
  p_cout_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cout_q && !all_clear) |=> cout_q);

  // R7: results hold while idle and no start arrives
  p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(sum) && $stable(cout)));

  // R6: a start seen while busy does not restart the step count
  p_busy_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !term) |=> (iter_cnt == $past(iter_cnt) + CW'(1)));
endmodule

// File: tb/iter_ha_adder_test.sv
module iter_ha_adder_test;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [W-1:0] opa = '0, opb = '0;
  logic [W-1:0] sum;
  logic cout, done;

  int total = 0, bad = 0;
  int cyc = 0;
  bit finished = 1'b0;
  bit prev_done = 1'b0;

  logic [W:0] q_exp[$];
  int         q_load[$];
  int         q_lat[$];   // -1: latency not fixed
  logic [W:0] last_res;

  always #2.5 clk = ~clk;

  iter_ha_adder #(.WIDTH(W)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .opa(opa), .opb(opb),
    .sum(sum), .cout(cout), .done(done)
  );

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input logic [W:0] act, input logic [W:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard when done is seen
  always @(negedge clk) begin
    if (rst_n) begin
      if (done) begin
        check(!prev_done, "R3 done pulse", {W'(0), prev_done}, '0);
        if (q_exp.size() == 0) begin
          check(1'b0, "R2 unexpected done", {cout, sum}, '0);
        end else begin
          logic [W:0] e;
          int l, x, lat;
          e = q_exp.pop_front();
          l = q_load.pop_front();
          x = q_lat.pop_front();
          lat = cyc - l + 1;
          check({cout, sum} == e, "R2 result", {cout, sum}, e);
          check(lat >= 1 && lat <= W, "R5 latency bound", (W+1)'(lat), (W+1)'(W));
          if (x == 1) check(lat == x, "R4 latency", (W+1)'(lat), (W+1)'(x));
          if (x > 1)  check(lat == x, "R5 worst latency", (W+1)'(lat), (W+1)'(x));
          last_res = {cout, sum};
        end
      end
      prev_done = done;
    end
  end

  task automatic wait_idle();
    while (q_exp.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic issue(input logic [W-1:0] a, input logic [W-1:0] b, input int lat);
    wait_idle();
    check(!done, "R3 no done while selecting operands", {W'(0), done}, '0);
    opa = a; opb = b; start = 1'b1;
    q_exp.push_back({1'b0, a} + {1'b0, b});
    q_load.push_back(cyc + 1);
    q_lat.push_back(lat);
    @(negedge clk);
    start = 1'b0;
    opa = $urandom; opb = $urandom;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check({cout, sum} == '0, "R1 reset outputs", {cout, sum}, '0);
    check(!done, "R1 reset done", {W'(0), done}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check({cout, sum} == '0 && !done, "R1 after release", {cout, sum}, '0);

    issue('1, '0, 1);                       // R4 no carries
    issue('1, W'(1), W);                    // R5 full ripple
    issue(32'h3F050FC0, 32'h01300041, -1);  // R2 mixed
    issue('1, '1, -1);                      // R2 carry out
    issue('0, '0, 1);                       // R4 zero operands
    issue(32'h80000000, 32'h80000000, 1);   // R4 top carry only

    // R6: starts during a long operation are ignored
    issue('1, W'(1), W);
    for (int k = 0; k < 4; k++) begin
      opa = $urandom; opb = $urandom; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      @(negedge clk);
    end
    wait_idle();
    check(last_res == {1'b1, W'(0)}, "R6 ignored start", last_res, {1'b1, W'(0)});
    check(q_exp.size() == 0, "R6 no extra result", (W+1)'(q_exp.size()), '0);

    // R7: outputs hold while idle and operands change
    for (int k = 0; k < 5; k++) begin
      opa = $urandom; opb = $urandom;
      @(negedge clk);
      check({cout, sum} == last_res, "R7 hold", {cout, sum}, last_res);
      check(!done, "R3 single done", {W'(0), done}, '0);
    end

    for (int k = 0; k < 300; k++) begin
      logic [W-1:0] a, b;
      a = $urandom; b = $urandom;
      if (k % 7 == 0) b = ~a;
      if (k % 11 == 0) b = W'(1) << (k % W);
      issue(a, b, -1);
    end
    wait_idle();
    check(q_exp.size() == 0, "R2 all results seen", (W+1)'(q_exp.size()), '0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog R2 actual=%0d expected=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule